// File: doc/BRIEF.md
# Packet-Granularity Credit Allocator

This block arbitrates several input flit streams onto one output link whose downstream buffer is tracked by a local credit counter. It works in one of two flow-control modes. In flit mode (wormhole), each flit needs one free buffer slot before it can leave. In packet mode (virtual cut-through), a packet is admitted only when the free slots cover its whole declared length. Those slots are reserved when the head flit leaves, and the rest of the packet then follows with no further credit check.

In both modes, a packet that has been granted owns the output until its tail flit has gone. Flits from different inputs are therefore never interleaved. When the output is free, a round-robin arbiter picks the next input. The arbiter pointer moves only when a head flit is actually taken. A chosen input that is waiting for credits therefore keeps its turn, and short packets cannot starve a long one.

Each input is a valid/ready stream. A flit moves when `in_valid` and `in_ready` are both high on a clock edge. A source holds its flit stable while `in_ready` is low. `in_ready` may depend on the `in_valid` pins of all inputs in the same cycle. The output has no ready pin: downstream back-pressure is expressed only through credits. `credit_ret` pulses once for every flit the downstream buffer dequeues. The mode pin is sampled per packet at its head flit. In packet mode, a source must send exactly as many flits as the head declares.

Top module: `pkt_credit_alloc`

## Requirements
- R1: After reset, `free_credits` equals DEPTH, and `out_valid`, every `in_ready` bit and `len_err` are low.
- R2: In flit mode, a flit is forwarded only while `free_credits` is at least 1, and each forwarded flit lowers the count by exactly one.
- R3: In packet mode, a head flit declaring L flits is forwarded only while `free_credits` is at least L. L is subtracted in the cycle the head leaves. Body and tail flits of that packet then pass with no credit check and no further deduction.
- R4: Once a head flit without the tail bit has been taken from input k, only input k can see `in_ready` until its tail flit has been taken. At most one `in_ready` bit is high in any cycle.
- R5: While no packet is in progress, the search starts at the input after the one whose head flit was last taken, with index order wrapping. An input that is chosen but blocked on credits stays chosen.
- R6: Each `credit_ret` pulse adds one credit, and the count never goes above DEPTH. A return and a deduction in the same cycle both take effect.
- R7: In packet mode, a head declaring length 0 or more than DEPTH starts a discard. Every flit of that packet is accepted and dropped, up to and including its tail. None of them appears on the output, and credits do not change. `len_err` is high for exactly the one cycle after the head was accepted.
- R8: The mode pin is sampled when a head flit is taken, and the packet keeps that mode until its tail. A packet admitted in packet mode continues at zero credits even if the pin then switches to flit mode.
- R9: `out_data`, `out_head` and `out_tail` mirror the flit on the selected input in the same cycle. `out_src` gives that input's index, and `out_valid` is high exactly when that flit is being forwarded.
- R10: The declared packet length is the unsigned value in bits [LEN_W-1:0] of the head flit's data. Flit mode ignores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_mode | input | 1 | 1 = packet mode, 0 = flit mode; sampled at each head flit |
| in_valid | input | N_IN | Flit present, one bit per input |
| in_ready | output | N_IN | Flit taken this cycle, one bit per input |
| in_data | input | N_IN*DATA_W | Flit payloads; input i occupies bits [i*DATA_W +: DATA_W] |
| in_head | input | N_IN | Head marker per input |
| in_tail | input | N_IN | Tail marker per input |
| credit_ret | input | 1 | One downstream slot freed |
| out_valid | output | 1 | Flit forwarded on the output this cycle |
| out_data | output | DATA_W | Forwarded payload |
| out_head | output | 1 | Forwarded flit is a head |
| out_tail | output | 1 | Forwarded flit is a tail |
| out_src | output | $clog2(N_IN) | Index of the input being served |
| free_credits | output | $clog2(DEPTH+1) | Current count of free downstream slots |
| len_err | output | 1 | One-cycle pulse after an illegal length was discarded |

## Verification
The bench aims at the edge where credits run out. In one case a long packet in flit mode drains the count to zero. A design that does not gate on one credit would overrun the downstream buffer, and one that charges the wrong amount would drift from the reference count. In packet mode, a packet that exactly matches the remaining credits, and another that is one short of the free count, show whether the length comparison is off by one. Flipping the mode pin right after an admitted head catches a design that re-reads the pin instead of holding the reservation: its body flits would stall at zero credits. Lengths of zero and above DEPTH check that the discard neither emits flits nor leaks credits. Credit returns while the count is already full check saturation. Simultaneous heads on all inputs expose any pointer that fails to rotate.

// File: rtl/pca_pkg.sv
package pca_pkg;

  // Output ownership state between head and tail flits
  typedef enum logic [1:0] {
    LK_FREE = 2'd0,  // no packet in progress, arbitration open
    LK_FLIT = 2'd1,  // wormhole packet: one credit per flit
    LK_PKT  = 2'd2,  // cut-through packet: credits already reserved
    LK_DROP = 2'd3   // illegal length: draining to tail, nothing forwarded
  } lock_e;

endpackage

// File: rtl/pca_rr_pick.sv
module pca_rr_pick #(
  parameter int N_IN  = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_IN-1:0]  req,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Scan from the highest offset down so the lowest offset from ptr wins
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = N_IN - 1; k >= 0; k--) begin
      int p;
      p = int'(ptr) + k;
      if (p >= N_IN) p = p - N_IN;
      if (req[p]) begin
        idx = IDX_W'(p);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pca_admit.sv
module pca_admit
  import pca_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 4,
  parameter int CNT_W = 4
) (
  input  lock_e            lk,
  input  logic             pkt_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic             drop,
  output logic             bad_len,
  output logic [CNT_W-1:0] dec
);

  localparam int CW = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

  logic [CW-1:0] len_x, cnt_x, depth_x;

  assign len_x   = CW'(len);
  assign cnt_x   = CW'(cnt);
  assign depth_x = CW'(DEPTH);

  assign bad_len = (len_x == '0) || (len_x > depth_x);

  always_comb begin
    ok   = 1'b0;
    drop = 1'b0;
    dec  = '0;
    unique case (lk)
      LK_FREE: begin
        if (pkt_mode) begin
          drop = bad_len;
          ok   = bad_len || (cnt_x >= len_x);
          dec  = bad_len ? '0 : CNT_W'(len);
        end else begin
          ok  = (cnt != '0);
          dec = CNT_W'(1);
        end
      end
      LK_FLIT: begin
        ok  = (cnt != '0);
        dec = CNT_W'(1);
      end
      LK_PKT: begin
        ok = 1'b1;
      end
      LK_DROP: begin
        ok   = 1'b1;
        drop = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pca_credit_ctr.sv
module pca_credit_ctr #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret,
  input  logic [CNT_W-1:0] dec,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W:0] sum;

  // dec never exceeds cnt: admission compares against the registered count
  assign sum = {1'b0, cnt} + (CNT_W + 1)'(ret) - {1'b0, dec};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CNT_W'(DEPTH);
    end else if (sum > (CNT_W + 1)'(DEPTH)) begin
      cnt <= CNT_W'(DEPTH);
    end else begin
      cnt <= sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/pkt_credit_alloc.sv
module pkt_credit_alloc
  import pca_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_mode,
  input  logic [N_IN-1:0]              in_valid,
  output logic [N_IN-1:0]              in_ready,
  input  logic [N_IN*DATA_W-1:0]       in_data,
  input  logic [N_IN-1:0]              in_head,
  input  logic [N_IN-1:0]              in_tail,
  input  logic                         credit_ret,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_head,
  output logic                         out_tail,
  output logic [$clog2(N_IN)-1:0]      out_src,
  output logic [$clog2(DEPTH+1)-1:0]   free_credits,
  output logic                         len_err
);

  localparam int IDX_W = $clog2(N_IN);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lock_e            lk_q;
  logic [IDX_W-1:0] owner_q, ptr_q, ptr_nxt;
  logic [IDX_W-1:0] pick_idx, sel;
  logic             pick_any;
  logic [DATA_W-1:0] sel_data;
  logic             sel_vld, sel_tail, sel_head;
  logic             ok, drop, bad_len, fire, fwd;
  logic [CNT_W-1:0] dec_amt, dec_eff, cnt;
  logic             err_q;

  pca_rr_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
    .req (in_valid),
    .ptr (ptr_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign sel      = (lk_q == LK_FREE) ? pick_idx : owner_q;
  assign sel_vld  = in_valid[sel] && ((lk_q != LK_FREE) || pick_any);
  assign sel_data = in_data[int'(sel)*DATA_W +: DATA_W];
  assign sel_head = in_head[sel];
  assign sel_tail = in_tail[sel];

  pca_admit #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_admit (
    .lk       (lk_q),
    .pkt_mode (pkt_mode),
    .cnt      (cnt),
    .len      (sel_data[LEN_W-1:0]),
    .ok       (ok),
    .drop     (drop),
    .bad_len  (bad_len),
    .dec      (dec_amt)
  );

  assign fire    = sel_vld && ok;
  assign fwd     = fire && !drop;
  assign dec_eff = fwd ? dec_amt : '0;

  pca_credit_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cred (
    .clk   (clk),
    .rst_n (rst_n),
    .ret   (credit_ret),
    .dec   (dec_eff),
    .cnt   (cnt)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_ready
    assign in_ready[i] = fire && (sel == IDX_W'(i));
  end

  assign ptr_nxt = (sel == IDX_W'(N_IN - 1)) ? '0 : sel + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_q    <= LK_FREE;
      owner_q <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= fire && (lk_q == LK_FREE) && drop;
      if (fire) begin
        if (lk_q == LK_FREE) begin
          ptr_q <= ptr_nxt;
          if (!sel_tail) begin
            owner_q <= sel;
            if (drop)          lk_q <= LK_DROP;
            else if (pkt_mode) lk_q <= LK_PKT;
            else               lk_q <= LK_FLIT;
          end
        end else if (sel_tail) begin
          lk_q <= LK_FREE;
        end
      end
    end
  end

  assign out_valid    = fwd;
  assign out_data     = sel_data;
  assign out_head     = sel_head;
  assign out_tail     = sel_tail;
  assign out_src      = sel;
  assign free_credits = cnt;
  assign len_err      = err_q;

  logic unused_ok;
  assign unused_ok = bad_len;

endmodule

// File: rtl/pca_chk.sv
module pca_chk #(
  parameter int N_IN   = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_mode,
  input logic [N_IN-1:0]   in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_head,
  input logic              out_tail,
  input logic [IDX_W-1:0]  out_src,
  input logic [CNT_W-1:0]  free_credits,
  input logic              len_err
);

  logic             open_q;
  logic [IDX_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      src_q  <= '0;
    end else if (out_valid) begin
      open_q <= !out_tail;
      src_q  <= out_src;
    end
  end

  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_credits) <= DEPTH);

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_credits) <= int'($past(free_credits)) + 1);

  a_r4_same_src: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && out_valid) |-> (out_src == src_q && !out_head));

  a_r4_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && out_valid) |-> out_head);

  a_r4_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  a_r2_head_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_head) |-> (free_credits != '0));

  a_r3_cover_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_head && pkt_mode && !open_q)
      |-> (int'(free_credits) >= int'(out_data[LEN_W-1:0])));

  a_r9_src_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready[out_src]);

  a_r7_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(pkt_mode));

endmodule

bind pkt_credit_alloc pca_chk #(
  .N_IN(N_IN), .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_head(out_head),
  .out_tail(out_tail), .out_src(out_src), .free_credits(free_credits),
  .len_err(len_err)
);

// File: tb/test_pkt_credit_alloc.sv
module test_pkt_credit_alloc;

  localparam int N_IN   = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 4;
  localparam int IDX_W  = $clog2(N_IN);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int FW     = DATA_W + 2;  // {head, tail, data}

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                       rst_n;
  logic                       pkt_mode;
  logic [N_IN-1:0]            in_valid, in_ready, in_head, in_tail;
  logic [N_IN*DATA_W-1:0]     in_data;
  logic                       credit_ret;
  logic                       out_valid, out_head, out_tail, len_err;
  logic [DATA_W-1:0]          out_data;
  logic [IDX_W-1:0]           out_src;
  logic [CNT_W-1:0]           free_credits;

  pkt_credit_alloc #(.N_IN(N_IN), .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W))
  i_pkt_credit_alloc (
    .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_head(in_head), .in_tail(in_tail),
    .credit_ret(credit_ret), .out_valid(out_valid), .out_data(out_data),
    .out_head(out_head), .out_tail(out_tail), .out_src(out_src),
    .free_credits(free_credits), .len_err(len_err)
  );

  logic [FW-1:0] srcq [N_IN][$];
  int src_log[$];

  int checks = 0, errors = 0, cyc = 0;
  int vld_pct = 100, ret_pct = 100, sink_occ = 0, err_seen = 0;
  bit mode_req = 1'b0, force_ret = 1'b0;

  // reference model state
  int m_cred = DEPTH, m_owner = 0, m_ptr = 0;
  bit m_locked = 0, m_lpkt = 0, m_ldrop = 0, m_err = 0;

  task automatic check(bit good, string req, string what, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic push_pkt(int i, int nfl, int lenf);
    for (int k = 0; k < nfl; k++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'($urandom);
      if (k == 0) d[LEN_W-1:0] = LEN_W'(lenf);
      srcq[i].push_back({(k == 0), (k == nfl - 1), d});
    end
  endtask

  task automatic cycle();
    int sel, len;
    bit ok, bad, fire, drop, fwd, pkt_now, ftail;
    @(negedge clk);
    pkt_mode = mode_req;
    for (int i = 0; i < N_IN; i++) begin
      bit v;
      v = (srcq[i].size() > 0) && (($urandom % 100) < vld_pct);
      in_valid[i] = v;
      if (v) begin
        in_head[i] = srcq[i][0][FW-1];
        in_tail[i] = srcq[i][0][FW-2];
        in_data[i*DATA_W +: DATA_W] = srcq[i][0][DATA_W-1:0];
      end else begin
        in_head[i] = 1'b0;
        in_tail[i] = 1'b0;
        in_data[i*DATA_W +: DATA_W] = '0;
      end
    end
    credit_ret = force_ret || ((sink_occ > 0) && (($urandom % 100) < ret_pct));
    #1;
    sel = -1;
    if (m_locked) sel = m_owner;
    else for (int k = 0; k < N_IN; k++) begin
      int p;
      p = (m_ptr + k) % N_IN;
      if (sel < 0 && in_valid[p]) sel = p;
    end
    fire = 0; drop = 0; len = 0; bad = 0; ftail = 0;
    if (sel >= 0 && in_valid[sel]) begin
      len   = int'(srcq[sel][0][LEN_W-1:0]);
      ftail = srcq[sel][0][FW-2];
      bad   = (len == 0) || (len > DEPTH);
      if (m_locked) begin
        ok = m_lpkt || (m_cred > 0);
        drop = m_ldrop;
      end else if (pkt_mode) begin
        ok = bad || (m_cred >= len);
        drop = bad;
      end else ok = (m_cred > 0);
      fire = ok;
    end
    fwd = fire && !drop;
    check(out_valid == fwd, "R2 R3 R10", "out_valid", out_valid, fwd);
    for (int i = 0; i < N_IN; i++)
      check(in_ready[i] == (fire && sel == i), "R4", "in_ready", in_ready[i], fire && sel == i);
    if (fwd) begin
      check(int'(out_src) == sel, "R5", "out_src", out_src, sel);
      check({out_head, out_tail, out_data} == srcq[sel][0], "R9", "out flit",
            {out_head, out_tail, out_data}, srcq[sel][0]);
      src_log.push_back(sel);
    end
    check(int'(free_credits) == m_cred, "R6", "free_credits", free_credits, m_cred);
    check(len_err == m_err, "R7", "len_err", len_err, m_err);
    if (len_err) err_seen++;
    @(posedge clk);
    pkt_now = m_locked ? m_lpkt : pkt_mode;
    begin
      int dec;
      dec = 0;
      if (fwd) dec = !pkt_now ? 1 : (!m_locked ? len : 0);
      m_cred = m_cred - dec + int'(credit_ret);
      if (m_cred > DEPTH) m_cred = DEPTH;
    end
    m_err = fire && !m_locked && drop;
    if (fwd) sink_occ++;
    if (credit_ret && sink_occ > 0) sink_occ--;
    if (fire) begin
      void'(srcq[sel].pop_front());
      if (!m_locked) begin
        m_ptr = (sel + 1) % N_IN;
        if (!ftail) begin
          m_locked = 1; m_owner = sel; m_lpkt = pkt_mode; m_ldrop = drop;
        end
      end else if (ftail) m_locked = 0;
    end
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  function automatic bit idle();
    for (int i = 0; i < N_IN; i++) if (srcq[i].size() != 0) return 0;
    return !m_locked && m_cred == DEPTH;
  endfunction

  task automatic drain();
    ret_pct = 100; vld_pct = 100;
    while (!idle()) cycle();
    cycle();
  endtask

  initial begin
    rst_n = 1'b0; pkt_mode = 1'b0; in_valid = '0; in_head = '0; in_tail = '0;
    in_data = '0; credit_ret = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(int'(free_credits) == DEPTH, "R1", "free_credits", free_credits, DEPTH);
    check(out_valid == 0 && in_ready == '0 && len_err == 0, "R1", "outputs idle",
          {out_valid, in_ready, len_err}, 0);
    rst_n = 1'b1;

    // R2: flit mode, no returns: exactly DEPTH flits leave
    mode_req = 0; ret_pct = 0; vld_pct = 100;
    push_pkt(2, 10, 10);
    run(20);
    check(srcq[2].size() == 2, "R2", "flits left waiting", srcq[2].size(), 2);
    check(free_credits == 0, "R2", "credits at zero", free_credits, 0);
    drain();

    // R3: packet one short of free credits waits
    mode_req = 1; ret_pct = 0;
    push_pkt(0, 2, 2);
    run(4);
    push_pkt(1, 7, 7);
    run(10);
    check(srcq[1].size() == 7, "R3", "long packet held", srcq[1].size(), 7);
    check(free_credits == 6, "R3", "credits kept", free_credits, 6);
    drain();

    // R8: exact-fit reservation survives a mode flip to flit mode
    mode_req = 0; ret_pct = 0;
    push_pkt(1, 4, 4);
    run(8);
    mode_req = 1;
    push_pkt(3, 4, 4);
    cycle();
    mode_req = 0;
    run(6);
    check(srcq[3].size() == 0, "R8", "body flits at zero credits", srcq[3].size(), 0);
    check(free_credits == 0, "R8", "credits", free_credits, 0);
    drain();

    // R7: illegal lengths are discarded
    mode_req = 1; err_seen = 0;
    push_pkt(2, 3, DEPTH + 3);
    push_pkt(0, 2, 0);
    drain();
    check(err_seen == 2, "R7", "error pulses", err_seen, 2);
    check(int'(free_credits) == DEPTH, "R7", "credits untouched", free_credits, DEPTH);

    // R6: returns while full saturate
    force_ret = 1; run(3); force_ret = 0; cycle();
    check(int'(free_credits) == DEPTH, "R6", "saturated", free_credits, DEPTH);

    // R5: simultaneous single-flit heads rotate
    mode_req = 0; src_log.delete();
    for (int r = 0; r < 3; r++) for (int i = 0; i < N_IN; i++) push_pkt(i, 1, 1);
    drain();
    for (int k = 1; k < src_log.size(); k++)
      check(src_log[k] == (src_log[k-1] + 1) % N_IN, "R5", "rotation",
            src_log[k], (src_log[k-1] + 1) % N_IN);

    // random traffic, both modes
    for (int ph = 0; ph < 2; ph++) begin
      mode_req = ph[0]; vld_pct = 70; ret_pct = 50;
      for (int p = 0; p < 40; p++) begin
        int n;
        n = ph == 0 ? 1 + $urandom % 6 : 1 + $urandom % DEPTH;
        push_pkt($urandom % N_IN, n, n);
      end
      while (!idle()) begin
        vld_pct = 70; ret_pct = 50;
        cycle();
      end
      drain();
    end

    finish_run();
  end

endmodule